// File: doc/BRIEF.md
# Banked Group-Enable Register with Access Checker

This block keeps the one-bit enable for an interrupt group in four storage copies: a secure bank, a non-secure bank, an unbanked copy used when the highest privilege level is absent, and a virtual copy. Software reaches it through a system-register request port. Each request carries the current privilege level (0 to 3), the security state, a monitor-mode flag and a set of routing, trap and enable controls. A fixed-priority decision picks exactly one outcome per request. The possible outcomes are: undefined, trap to level 2, trap to level 3, access to the virtual copy, or access to one bank.

The outcome, the read data and a trap syndrome are registered and appear one cycle after the request. Only an access outcome reads or writes a copy. A write can move a bank copy from 1 to 0 while an interrupt is pending. In that case the block pulses a release request, so that the pending interrupt can be forwarded elsewhere.

Top module: `grpen_access_unit`

## Requirements
- R1: The register is 32 bits wide. Read data carries the enable in bit 0 and zero in bits 31:1. A write stores only bit 0 of the write data.
- R2: A request at privilege level 0 always gives the undefined outcome.
- R3: At level 1 the first four checks run in this order. First, undefined when level 3 exists, the undefined-priority flag is set, and level-3 IRQ routing is set outside monitor mode. Second, trap to level 2 when level 2 is enabled and the coarse trap bit is set. Third, undefined when the level-1 SRE bit is 0. Fourth, trap to level 2 when level 2 is enabled and the group trap bit is set.
- R4: At level 1, once those checks pass, the next two rules apply in order. First, if level 2 is enabled and hypervisor routing is set, the request accesses the virtual copy. Second, if level 3 exists and level-3 IRQ routing is set outside monitor mode, the outcome is undefined when the strict flag is set and trap to level 3 otherwise.
- R5: At level 2 the checks run in this order: the level-3 undefined-priority check, then undefined when the level-2 SRE bit is 0, then the level-3 routing check (undefined or trap to level 3). Level 2 never traps to itself and never uses the virtual copy. The monitor-mode flag does not gate the level-3 routing checks at this level.
- R6: A level-1 or level-2 request that passes every check accesses the non-secure bank when level 3 exists, and the unbanked copy otherwise.
- R7: At level 3 the outcome is undefined when the level-3 SRE bit is 0. Otherwise the request accesses the secure bank in the secure state and the non-secure bank in the non-secure state.
- R8: The outcome is registered and one-hot, one cycle after the request: bit 0 undefined, bit 1 trap to level 2, bit 2 trap to level 3, bit 3 virtual access, bit 4 bank access. Without a request the outcome is all zero. The syndrome is 0x03 on either trap and 0 otherwise.
- R9: Only a write with a virtual or bank outcome changes a copy. Reads and non-access outcomes leave all four enable outputs unchanged.
- R10: Synchronous active-low reset clears all four copies, the response outputs and the release output.
- R11: A write that takes a bank copy (secure, non-secure or unbanked) from 1 to 0, while the interrupt-pending input is high in the request cycle, raises the release output for exactly one cycle, two cycles after the request.
- R12: No release pulse follows a request whose pending input was low, a write to the virtual copy, or a write that leaves the copy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data |
| priv_lvl | input | 2 | Current privilege level |
| sec_state | input | 1 | 1 when the requester is secure |
| mon_mode | input | 1 | Requester is in monitor mode |
| has_l3 | input | 1 | Level 3 is implemented |
| l2_enabled | input | 1 | Level 2 is enabled |
| undef_prio | input | 1 | Undefined-priority flag for level-3 routing |
| strict_undef | input | 1 | Level-3 routing yields undefined instead of a trap |
| irq_to_l3 | input | 1 | IRQ routed to level 3 |
| coarse_trap | input | 1 | Level-2 coarse trap of this register group |
| grp1_trap | input | 1 | Level-2 trap of all group accesses |
| sre_l1 | input | 1 | Level-1 system-register enable |
| sre_l2 | input | 1 | Level-2 system-register enable |
| sre_l3 | input | 1 | Level-3 system-register enable |
| route_hyp | input | 1 | IRQ routed to the hypervisor |
| irq_pending | input | 1 | An interrupt is pending in the CPU interface |
| rsp_valid | output | 1 | Response valid |
| rsp_outcome | output | 5 | One-hot outcome |
| rsp_syndrome | output | 6 | Trap syndrome code |
| rsp_rdata | output | 32 | Read data |
| en_secure | output | 1 | Secure bank enable |
| en_nonsecure | output | 1 | Non-secure bank enable |
| en_flat | output | 1 | Unbanked copy enable |
| en_virtual | output | 1 | Virtual copy enable |
| release_pulse | output | 1 | Release request for the pending interrupt |

## Verification
The assertions assume that at most one request arrives per cycle and that `has_l3` is high whenever `priv_lvl` is 3. A level-3 request on a part without level 3 would be incoherent. The stimulus keeps both conditions in its directed and random phases: it raises `has_l3` on every level-3 request. The SRE bits are biased high so that most requests get past the enable checks and reach the bank and virtual outcomes. The routing and trap bits are set often enough to reach every branch of both priority chains.

// File: rtl/grpen_pkg.sv
// Shared types of the banked group-enable block.
// Assumes the one-hot outcome encoding is decoded by the exception logic.
package grpen_pkg;

    localparam int OUT_W    = 5;
    localparam int N_COPIES = 4;

    typedef enum logic [OUT_W-1:0] {
        OC_NONE  = 5'b00000,
        OC_UNDEF = 5'b00001,
        OC_TRAP2 = 5'b00010,
        OC_TRAP3 = 5'b00100,
        OC_VIRT  = 5'b01000,
        OC_BANK  = 5'b10000
    } outcome_e;

    typedef enum logic [1:0] {
        CP_SEC  = 2'd0,
        CP_NSEC = 2'd1,
        CP_FLAT = 2'd2,
        CP_VIRT = 2'd3
    } copy_e;

    typedef struct packed {
        logic has_l3;
        logic l2_en;
        logic undef_prio;
        logic strict_undef;
        logic irq_to_l3;
        logic coarse_trap;
        logic grp1_trap;
        logic sre_l1;
        logic sre_l2;
        logic sre_l3;
        logic route_hyp;
    } ctl_t;

endpackage

// File: rtl/grpen_route.sv
// Access decision: a fixed-priority chain per privilege level picks one
// outcome and, for an access, the storage copy it touches.
// Assumes has_l3 is set whenever priv_lvl is 3. Purely combinational.
module grpen_route
    import grpen_pkg::*;
(
    input  logic [1:0] priv_lvl,
    input  logic       sec_state,
    input  logic       mon_mode,
    input  ctl_t       ctl,
    output outcome_e   outcome,
    output copy_e      target
);

    logic  l3_route;
    copy_e low_bank;

    // Level-3 IRQ routing; monitor mode only masks it at level 1.
    always_comb begin
        l3_route = ctl.has_l3 && ctl.irq_to_l3 && ((priv_lvl == 2'd2) || !mon_mode);
        low_bank = ctl.has_l3 ? CP_NSEC : CP_FLAT;
    end

    // Priority chain selecting the outcome and the target copy.
    always_comb begin
        outcome = OC_UNDEF;
        target  = low_bank;
        case (priv_lvl)
            2'd0: outcome = OC_UNDEF;
            2'd1: begin
                if (l3_route && ctl.undef_prio)            outcome = OC_UNDEF;
                else if (ctl.l2_en && ctl.coarse_trap)     outcome = OC_TRAP2;
                else if (!ctl.sre_l1)                      outcome = OC_UNDEF;
                else if (ctl.l2_en && ctl.grp1_trap)       outcome = OC_TRAP2;
                else if (ctl.l2_en && ctl.route_hyp) begin
                    outcome = OC_VIRT;
                    target  = CP_VIRT;
                end
                else if (l3_route)                         outcome = ctl.strict_undef ? OC_UNDEF : OC_TRAP3;
                else                                       outcome = OC_BANK;
            end
            2'd2: begin
                if (l3_route && ctl.undef_prio)            outcome = OC_UNDEF;
                else if (!ctl.sre_l2)                      outcome = OC_UNDEF;
                else if (l3_route)                         outcome = ctl.strict_undef ? OC_UNDEF : OC_TRAP3;
                else                                       outcome = OC_BANK;
            end
            default: begin
                if (!ctl.sre_l3) outcome = OC_UNDEF;
                else begin
                    outcome = OC_BANK;
                    target  = sec_state ? CP_SEC : CP_NSEC;
                end
            end
        endcase
    end

endmodule

// File: rtl/grpen_store.sv
// Storage of the four enable copies (secure, non-secure, unbanked, virtual).
// Assumes wr_en is only raised for access outcomes. Flags a 1-to-0 write
// of a physical bank copy for the release logic.
module grpen_store
    import grpen_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int EN_BIT = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  copy_e               target,
    input  logic [REG_W-1:0]    wdata,
    output logic [N_COPIES-1:0] copies,
    output logic                rd_bit,
    output logic                drop
);

    logic wbit;

    // Only the enable bit of the write data is kept.
    always_comb wbit = wdata[EN_BIT];

    for (genvar c = 0; c < N_COPIES; c++) begin : g_copy
        // One flop per copy, written when the access targets it.
        always_ff @(posedge clk) begin
            if (!rst_n)                                    copies[c] <= 1'b0;
            else if (wr_en && (target == copy_e'(c)))      copies[c] <= wbit;
        end
    end

    // Read mux and physical-bank clear detection.
    always_comb begin
        rd_bit = copies[target];
        drop   = wr_en && (target != CP_VIRT) && copies[target] && !wbit;
    end

endmodule

// File: rtl/grpen_release.sv
// Release request generator: a bank clear with a pending interrupt gives a
// one-cycle pulse one cycle after the enable falls.
// Assumes irq_pending is sampled in the request cycle.
module grpen_release (
    input  logic clk,
    input  logic rst_n,
    input  logic drop,
    input  logic irq_pending,
    output logic release_pulse
);

    logic drop_q;

    // Two-stage pulse: capture the clear, then emit the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_q        <= 1'b0;
            release_pulse <= 1'b0;
        end else begin
            drop_q        <= drop && irq_pending;
            release_pulse <= drop_q;
        end
    end

    a_r11_release_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && irq_pending) |=> ##1 release_pulse);
    a_r12_no_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(drop && irq_pending) |=> ##1 !release_pulse);

endmodule

// File: rtl/grpen_access_unit.sv
// Banked group-enable register behind a system-register access port.
// Decides the outcome of each request, updates the targeted copy and
// registers the response. Assumes one request per cycle at most.
module grpen_access_unit
    import grpen_pkg::*;
#(
    parameter int          REG_W     = 32,
    parameter int          EN_BIT    = 0,
    parameter int          SYN_W     = 6,
    parameter logic [5:0]  TRAP_CODE = 6'h03
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [REG_W-1:0] req_wdata,
    input  logic [1:0]       priv_lvl,
    input  logic             sec_state,
    input  logic             mon_mode,
    input  logic             has_l3,
    input  logic             l2_enabled,
    input  logic             undef_prio,
    input  logic             strict_undef,
    input  logic             irq_to_l3,
    input  logic             coarse_trap,
    input  logic             grp1_trap,
    input  logic             sre_l1,
    input  logic             sre_l2,
    input  logic             sre_l3,
    input  logic             route_hyp,
    input  logic             irq_pending,
    output logic             rsp_valid,
    output logic [OUT_W-1:0] rsp_outcome,
    output logic [SYN_W-1:0] rsp_syndrome,
    output logic [REG_W-1:0] rsp_rdata,
    output logic             en_secure,
    output logic             en_nonsecure,
    output logic             en_flat,
    output logic             en_virtual,
    output logic             release_pulse
);

    localparam logic [REG_W-1:0] EN_MASK = REG_W'(1) << EN_BIT;

    ctl_t                ctl;
    outcome_e            oc;
    copy_e               target;
    logic                is_access;
    logic                is_trap;
    logic [N_COPIES-1:0] copies;
    logic                rd_bit;
    logic                drop;
    logic [REG_W-1:0]    rd_word;

    // Gather the control inputs into one record.
    always_comb begin
        ctl = '{has_l3: has_l3, l2_en: l2_enabled, undef_prio: undef_prio,
                strict_undef: strict_undef, irq_to_l3: irq_to_l3,
                coarse_trap: coarse_trap, grp1_trap: grp1_trap,
                sre_l1: sre_l1, sre_l2: sre_l2, sre_l3: sre_l3,
                route_hyp: route_hyp};
    end

    grpen_route u_route (
        .priv_lvl  (priv_lvl),
        .sec_state (sec_state),
        .mon_mode  (mon_mode),
        .ctl       (ctl),
        .outcome   (oc),
        .target    (target)
    );

    // Classify the chosen outcome.
    always_comb begin
        is_access = req_valid && ((oc == OC_BANK) || (oc == OC_VIRT));
        is_trap   = (oc == OC_TRAP2) || (oc == OC_TRAP3);
    end

    grpen_store #(.REG_W(REG_W), .EN_BIT(EN_BIT)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (is_access && req_write),
        .target (target),
        .wdata  (req_wdata),
        .copies (copies),
        .rd_bit (rd_bit),
        .drop   (drop)
    );

    grpen_release u_release (
        .clk           (clk),
        .rst_n         (rst_n),
        .drop          (drop),
        .irq_pending   (irq_pending),
        .release_pulse (release_pulse)
    );

    // Place the enable bit in an otherwise zero read word.
    always_comb begin
        rd_word         = '0;
        rd_word[EN_BIT] = rd_bit;
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_outcome  <= OC_NONE;
            rsp_syndrome <= '0;
            rsp_rdata    <= '0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_outcome  <= req_valid ? oc : OC_NONE;
            rsp_syndrome <= (req_valid && is_trap) ? SYN_W'(TRAP_CODE) : '0;
            rsp_rdata    <= (is_access && !req_write) ? rd_word : '0;
        end
    end

    // Expose the stored copies.
    always_comb begin
        en_secure    = copies[CP_SEC];
        en_nonsecure = copies[CP_NSEC];
        en_flat      = copies[CP_FLAT];
        en_virtual   = copies[CP_VIRT];
    end

    a_r1_res0_bits: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_rdata & ~EN_MASK) == '0));
    a_r2_level0_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && priv_lvl == 2'd0) |=> (rsp_outcome == OC_UNDEF));
    a_r5_level2_no_self: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && priv_lvl == 2'd2) |=> (!rsp_outcome[1] && !rsp_outcome[3]));
    a_r7_level3_sre: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && priv_lvl == 2'd3 && !sre_l3) |=> (rsp_outcome == OC_UNDEF));
    a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones(rsp_outcome) == 1));
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (rsp_outcome == OC_NONE && !rsp_valid));
    a_r9_no_access_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_access || !req_write) |=> $stable({en_secure, en_nonsecure, en_flat, en_virtual}));

endmodule

// File: tb/test_grpen_access_unit.sv
`timescale 1ns/1ps
module test_grpen_access_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  priv_lvl = '0;
    logic        sec_state = 0, mon_mode = 0, has_l3 = 0, l2_enabled = 0;
    logic        undef_prio = 0, strict_undef = 0, irq_to_l3 = 0, coarse_trap = 0;
    logic        grp1_trap = 0, sre_l1 = 0, sre_l2 = 0, sre_l3 = 0, route_hyp = 0;
    logic        irq_pending = 0;
    logic        rsp_valid;
    logic [4:0]  rsp_outcome;
    logic [5:0]  rsp_syndrome;
    logic [31:0] rsp_rdata;
    logic        en_secure, en_nonsecure, en_flat, en_virtual, release_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state: copies 0 secure, 1 non-secure, 2 unbanked, 3 virtual
    bit          mem [4];
    logic        e_valid;
    logic [4:0]  e_out;
    logic [5:0]  e_syn;
    logic [31:0] e_rd;
    bit          e_rel, rel_stage;
    string       e_tag;

    always #4 clk = ~clk;

    grpen_access_unit i_grpen_access_unit (.*);

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(rsp_valid === e_valid, "R8", "valid", 32'(rsp_valid), 32'(e_valid));
        chk(rsp_outcome === e_out, e_tag, "outcome", 32'(rsp_outcome), 32'(e_out));
        chk(rsp_syndrome === e_syn, "R8", "syndrome", 32'(rsp_syndrome), 32'(e_syn));
        chk(rsp_rdata === e_rd, "R1", "rdata", rsp_rdata, e_rd);
        chk({en_secure, en_nonsecure, en_flat, en_virtual} === {mem[0], mem[1], mem[2], mem[3]},
            "R9", "copies", 32'({en_secure, en_nonsecure, en_flat, en_virtual}),
            32'({mem[0], mem[1], mem[2], mem[3]}));
        chk(release_pulse === e_rel, e_rel ? "R11" : "R12", "release",
            32'(release_pulse), 32'(e_rel));
    endtask

    // Behavioural decision from the requirements; returns outcome, copy, tag.
    task automatic decide(output logic [4:0] oc, output int cp, output string tag);
        bit l3r;
        l3r = has_l3 && irq_to_l3 && (priv_lvl == 2 || !mon_mode);
        cp  = has_l3 ? 1 : 2;
        oc  = 5'b00001;
        tag = "R2";
        if (priv_lvl == 1) begin
            tag = "R3";
            if (l3r && undef_prio) oc = 5'b00001;
            else if (l2_enabled && coarse_trap) oc = 5'b00010;
            else if (!sre_l1) oc = 5'b00001;
            else if (l2_enabled && grp1_trap) oc = 5'b00010;
            else begin
                tag = "R4";
                if (l2_enabled && route_hyp) begin oc = 5'b01000; cp = 3; end
                else if (l3r) oc = strict_undef ? 5'b00001 : 5'b00100;
                else begin oc = 5'b10000; tag = "R6"; end
            end
        end else if (priv_lvl == 2) begin
            tag = "R5";
            if (l3r && undef_prio) oc = 5'b00001;
            else if (!sre_l2) oc = 5'b00001;
            else if (l3r) oc = strict_undef ? 5'b00001 : 5'b00100;
            else begin oc = 5'b10000; tag = "R6"; end
        end else if (priv_lvl == 3) begin
            tag = "R7";
            if (!sre_l3) oc = 5'b00001;
            else begin oc = 5'b10000; cp = sec_state ? 0 : 1; end
        end
    endtask

    // Advance the model over one edge, then compare at the next falling edge.
    task automatic tick();
        logic [4:0] oc;
        int cp;
        string tag;
        bit drop;
        drop = 0;
        decide(oc, cp, tag);
        e_rel = rel_stage;
        if (req_valid) begin
            e_valid = 1;
            e_out   = oc;
            e_tag   = tag;
            e_syn   = (oc == 5'b00010 || oc == 5'b00100) ? 6'h03 : 6'h00;
            e_rd    = '0;
            if (oc == 5'b10000 || oc == 5'b01000) begin
                if (req_write) begin
                    drop = (cp != 3) && mem[cp] && !req_wdata[0] && irq_pending;
                    mem[cp] = req_wdata[0];
                end else e_rd = {31'b0, mem[cp]};
            end
        end else begin
            e_valid = 0; e_out = '0; e_syn = '0; e_rd = '0; e_tag = "R8";
        end
        rel_stage = drop;
        @(negedge clk);
        compare();
    endtask

    task automatic base();
        req_valid = 1; req_write = 0; req_wdata = '0; sec_state = 0; mon_mode = 0;
        has_l3 = 1; l2_enabled = 0; undef_prio = 0; strict_undef = 0; irq_to_l3 = 0;
        coarse_trap = 0; grp1_trap = 0; sre_l1 = 1; sre_l2 = 1; sre_l3 = 1;
        route_hyp = 0; irq_pending = 0;
    endtask

    task automatic req(input int lvl, input bit wr, input logic [31:0] d);
        priv_lvl = 2'(lvl); req_write = wr; req_wdata = d; tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({rsp_valid, rsp_outcome, rsp_syndrome, en_secure, en_nonsecure, en_flat,
             en_virtual, release_pulse} === '0 && rsp_rdata === '0, "R10", "reset state",
            32'({rsp_valid, rsp_outcome}), 32'h0);
        foreach (mem[i]) mem[i] = 0;
        e_valid = 0; e_out = '0; e_syn = '0; e_rd = '0; e_rel = 0; rel_stage = 0; e_tag = "R8";
        rst_n = 1;
        // R7 level-3 bank selection by security state
        base(); sec_state = 1; req(3, 1, 32'hFFFF_FFFF);
        base(); req(3, 1, 32'h0000_0001);
        // R1 upper write bits dropped; read back non-secure through level 1
        base(); req(1, 0, '0);
        base(); req(3, 1, 32'hFFFF_FFFE);
        base(); req(3, 1, 32'h1);
        // R11 clear with pending interrupt, then idle for the pulse
        base(); irq_pending = 1; req(1, 1, 32'h0);
        req_valid = 0; tick(); tick();
        // R2 level 0
        base(); req(0, 1, 32'h1);
        // R3 ordering
        base(); l2_enabled = 1; coarse_trap = 1; sre_l1 = 0; req(1, 0, '0);
        base(); undef_prio = 1; irq_to_l3 = 1; l2_enabled = 1; coarse_trap = 1; req(1, 0, '0);
        base(); undef_prio = 1; irq_to_l3 = 1; mon_mode = 1; l2_enabled = 1; coarse_trap = 1; req(1, 0, '0);
        base(); sre_l1 = 0; l2_enabled = 1; grp1_trap = 1; req(1, 0, '0);
        base(); l2_enabled = 1; grp1_trap = 1; route_hyp = 1; req(1, 0, '0);
        // R4 virtual redirect beats level-3 routing, then routing alone
        base(); l2_enabled = 1; route_hyp = 1; irq_to_l3 = 1; req(1, 1, 32'h1);
        base(); l2_enabled = 1; route_hyp = 1; irq_pending = 1; req(1, 1, 32'h0);
        base(); irq_to_l3 = 1; strict_undef = 1; req(1, 1, 32'h1);
        base(); irq_to_l3 = 1; req(1, 1, 32'h1);
        // R5 level 2 ignores its own traps and virtual routing
        base(); l2_enabled = 1; coarse_trap = 1; grp1_trap = 1; route_hyp = 1; req(2, 1, 32'h1);
        base(); sre_l2 = 0; req(2, 0, '0);
        base(); irq_to_l3 = 1; mon_mode = 1; req(2, 0, '0);
        base(); irq_to_l3 = 1; undef_prio = 1; mon_mode = 1; req(2, 0, '0);
        // R6 unbanked copy without level 3
        base(); has_l3 = 0; irq_to_l3 = 1; req(1, 1, 32'h1);
        base(); has_l3 = 0; req(2, 0, '0);
        // R7 SRE off; R12 clear without pending
        base(); sre_l3 = 0; req(3, 1, 32'h0);
        base(); sec_state = 1; req(3, 1, 32'h0);
        req_valid = 0; tick(); tick();
        // random phase
        for (int n = 0; n < 4000; n++) begin
            req_valid   = ($urandom % 4) != 0;
            req_write   = $urandom % 2;
            req_wdata   = $urandom;
            priv_lvl    = 2'($urandom % 4);
            sec_state   = $urandom % 2;
            mon_mode    = ($urandom % 4) == 0;
            has_l3      = (priv_lvl == 3) ? 1'b1 : 1'($urandom % 2);
            l2_enabled  = $urandom % 2;
            undef_prio  = ($urandom % 4) == 0;
            strict_undef= $urandom % 2;
            irq_to_l3   = ($urandom % 4) == 0;
            coarse_trap = ($urandom % 6) == 0;
            grp1_trap   = ($urandom % 6) == 0;
            sre_l1      = ($urandom % 8) != 0;
            sre_l2      = ($urandom % 8) != 0;
            sre_l3      = ($urandom % 8) != 0;
            route_hyp   = ($urandom % 4) == 0;
            irq_pending = $urandom % 2;
            tick();
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule